// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block frees a two-wire serial bus that a target device has wedged, for example by holding the data line low partway through a transfer. When a request arrives while the block is idle, it first leaves both lines floating. It then generates nine clock pulses on SCL. After each rising edge it samples SDA, and it remembers whether SDA was ever high. Clocking always runs the full nine pulses, so a target that is partway through a byte can shift out its remaining bits and let go of the line.

If SDA was high at any sample, the block checks that both lines are at rest. It then pulls SDA low and releases it while SCL stays released (high) throughout. This forms a START immediately followed by a STOP, without the clock low phase between them that some targets mishandle. The block then waits out the bus-free interval before it reports. If SDA never went high, the START/STOP step is skipped and the block reports failure.

Both lines are open-drain: the block only ever drives a line low or releases it. The line inputs pass through synchronizers. After each release of SCL the block waits for the line to read high, which allows a target to stretch the clock, up to a bounded limit. A one-cycle `done` pulse ends each request, and `success` and `warnNotIdle` are valid with that pulse.

Top module: `i2crec_top`

## Requirements
- R1: After reset, and whenever `busy` is low, both `sclDriveLow` and `sdaDriveLow` are 0. After reset, `done`, `success` and `warnNotIdle` are also 0.
- R2: A `startReq` seen while idle starts one recovery run. In that run `sclDriveLow` goes high exactly NUM_PULSES (9) times, and each low phase lasts exactly HALF_CYC clock cycles.
- R3: After each release of SCL, the next low phase does not begin until the synchronized SCL line reads high or STRETCH_CYC cycles have passed, whichever comes first. A stretch longer than the limit therefore does not stop the run.
- R4: SDA is sampled once after each SCL rise, and the samples are ORed into a flag that is cleared at the start of the run. All nine pulses are generated whether or not SDA has already been seen high.
- R5: If SDA was never seen high, `sdaDriveLow` stays 0 for the whole run and `success` is 0 with `done`.
- R6: If SDA was seen high, `sdaDriveLow` is asserted exactly once, for exactly CLK_PER_US cycles (1 µs). `sclDriveLow` is 0 throughout that pulse, and `success` is 1 with `done`.
- R7: `warnNotIdle` is 1 with `done` only when SDA was seen high and at least one line read low at the check made after the ninth pulse. Otherwise it is 0.
- R8: After `sdaDriveLow` is released at the end of the START/STOP pair, `done` comes no sooner than BUF_US × CLK_PER_US cycles (60 µs) later.
- R9: `done` is high for exactly one cycle per run, and `busy` is low while `done` is high.
- R10: A `startReq` that arrives while `busy` is high is ignored. It does not add SCL pulses and does not produce a second `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request a recovery run (accepted only when idle) |
| sclIn | input | 1 | Sensed level of the SCL line |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| success | output | 1 | SDA was seen high during the run; valid with `done` |
| warnNotIdle | output | 1 | A line was low at the check before START/STOP; valid with `done` |

## Verification
The assertions take for granted that `startReq` is a synchronous level sampled on the clock, and that the bus is only ever pulled low by the sequencer or by a target. The bench models exactly this: the line levels are the wired-AND of the block's drives and a behavioral target, and that target changes SDA only at falling SCL edges and holds SCL low for a programmed stretch after each release. All stimulus is applied one time unit after a rising edge. A stretch beyond the limit is included on purpose to check the timeout path.

// File: rtl/i2crec_pkg.sv
package i2crec_pkg;

  typedef enum logic [1:0] {
    TM_HALF,
    TM_STRETCH,
    TM_US,
    TM_BUF
  } tsel_e;

  typedef struct packed {
    logic  clearFlags;
    logic  sampleSda;
    logic  checkIdle;
    logic  bumpCount;
    logic  sclLow;
    logic  sdaLow;
    logic  pulseDone;
    logic  timerLoad;
    tsel_e timerSel;
  } strobe_t;

  typedef struct packed {
    logic timerZero;
    logic lastPulse;
    logic sclHigh;
    logic seenHigh;
  } status_t;

endpackage

// File: rtl/i2crec_dp.sv
module i2crec_dp
  import i2crec_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter int HALF_CYC    = 8,
  parameter int STRETCH_CYC = 64,
  parameter int BUF_US      = 60,
  parameter int NUM_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t stb,
  input  logic    sclIn,
  input  logic    sdaIn,
  output status_t sts,
  output logic    sclDriveLow,
  output logic    sdaDriveLow,
  output logic    done,
  output logic    success,
  output logic    warnNotIdle
);

  localparam int BUF_CYC = BUF_US * CLK_PER_US;
  localparam int MAX_A   = (HALF_CYC > STRETCH_CYC) ? HALF_CYC : STRETCH_CYC;
  localparam int MAX_B   = (CLK_PER_US > BUF_CYC) ? CLK_PER_US : BUF_CYC;
  localparam int TMAX    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW      = $clog2(TMAX + 1);
  localparam int CW      = $clog2(NUM_PULSES + 1);

  logic          sclS;
  logic          sdaS;
  logic [TW-1:0] timer;
  logic [CW-1:0] pulseCnt;
  logic          seenHigh;

  // Input synchronizers; reset to the released (high) level.
  if (SYNC_STAGES > 1) begin : g_sync
    logic [SYNC_STAGES-1:0] sclPipe;
    logic [SYNC_STAGES-1:0] sdaPipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclPipe <= '1;
        sdaPipe <= '1;
      end else begin
        sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
        sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      end
    end
    assign sclS = sclPipe[SYNC_STAGES-1];
    assign sdaS = sdaPipe[SYNC_STAGES-1];
  end else begin : g_single
    logic sclQ;
    logic sdaQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sclQ <= 1'b1;
        sdaQ <= 1'b1;
      end else begin
        sclQ <= sclIn;
        sdaQ <= sdaIn;
      end
    end
    assign sclS = sclQ;
    assign sdaS = sdaQ;
  end

  // Down-counting interval timer, loaded with length minus one.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (stb.timerLoad) begin
      unique case (stb.timerSel)
        TM_HALF:    timer <= TW'(HALF_CYC - 1);
        TM_STRETCH: timer <= TW'(STRETCH_CYC - 1);
        TM_US:      timer <= TW'(CLK_PER_US - 1);
        default:    timer <= TW'(BUF_CYC - 1);
      endcase
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt    <= '0;
      seenHigh    <= 1'b0;
      warnNotIdle <= 1'b0;
      success     <= 1'b0;
      done        <= 1'b0;
      sclDriveLow <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else begin
      sclDriveLow <= stb.sclLow;
      sdaDriveLow <= stb.sdaLow;
      done        <= stb.pulseDone;
      if (stb.clearFlags) begin
        pulseCnt    <= '0;
        seenHigh    <= 1'b0;
        warnNotIdle <= 1'b0;
        success     <= 1'b0;
      end else begin
        if (stb.bumpCount) pulseCnt <= pulseCnt + 1'b1;
        if (stb.sampleSda) seenHigh <= seenHigh | sdaS;
        if (stb.checkIdle) warnNotIdle <= !(sclS && sdaS);
        if (stb.pulseDone) success <= seenHigh;
      end
    end
  end

  assign sts.timerZero = (timer == '0);
  assign sts.lastPulse = (pulseCnt == CW'(NUM_PULSES - 1));
  assign sts.sclHigh   = sclS;
  assign sts.seenHigh  = seenHigh;

endmodule

// File: rtl/i2crec_ctrl.sv
module i2crec_ctrl
  import i2crec_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  status_t sts,
  output strobe_t stb,
  output logic    busy
);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RELEASE,
    ST_CLK_LOW,
    ST_CLK_RISE,
    ST_CLK_HIGH,
    ST_CHECK,
    ST_SETUP,
    ST_SDA_LOW,
    ST_BUS_FREE,
    ST_FINISH
  } state_e;

  state_e state;
  state_e nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    stb          = '0;
    stb.timerSel = TM_HALF;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stb.clearFlags = 1'b1;
          stb.timerLoad  = 1'b1;
          nextState      = ST_RELEASE;
        end
      end
      ST_RELEASE: begin
        if (sts.timerZero) begin
          stb.timerLoad = 1'b1;
          nextState     = ST_CLK_LOW;
        end
      end
      ST_CLK_LOW: begin
        stb.sclLow = 1'b1;
        if (sts.timerZero) begin
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_STRETCH;
          nextState     = ST_CLK_RISE;
        end
      end
      ST_CLK_RISE: begin
        if (sts.sclHigh || sts.timerZero) begin
          stb.sampleSda = 1'b1;
          stb.timerLoad = 1'b1;
          nextState     = ST_CLK_HIGH;
        end
      end
      ST_CLK_HIGH: begin
        if (sts.timerZero) begin
          stb.bumpCount = 1'b1;
          if (sts.lastPulse) begin
            nextState = ST_CHECK;
          end else begin
            stb.timerLoad = 1'b1;
            nextState     = ST_CLK_LOW;
          end
        end
      end
      ST_CHECK: begin
        if (sts.seenHigh) begin
          stb.checkIdle = 1'b1;
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_US;
          nextState     = ST_SETUP;
        end else begin
          nextState = ST_FINISH;
        end
      end
      ST_SETUP: begin
        if (sts.timerZero) begin
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_US;
          nextState     = ST_SDA_LOW;
        end
      end
      ST_SDA_LOW: begin
        stb.sdaLow = 1'b1;
        if (sts.timerZero) begin
          stb.timerLoad = 1'b1;
          stb.timerSel  = TM_BUF;
          nextState     = ST_BUS_FREE;
        end
      end
      ST_BUS_FREE: begin
        if (sts.timerZero) nextState = ST_FINISH;
      end
      default: begin
        stb.pulseDone = 1'b1;
        nextState     = ST_IDLE;
      end
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/i2crec_top.sv
module i2crec_top
  import i2crec_pkg::*;
#(
  parameter int CLK_PER_US  = 4,
  parameter int HALF_CYC    = 8,
  parameter int STRETCH_CYC = 64,
  parameter int BUF_US      = 60,
  parameter int NUM_PULSES  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclDriveLow,
  output logic sdaDriveLow,
  output logic busy,
  output logic done,
  output logic success,
  output logic warnNotIdle
);

  strobe_t stb;
  status_t sts;

  i2crec_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .sts      (sts),
    .stb      (stb),
    .busy     (busy)
  );

  i2crec_dp #(
    .CLK_PER_US  (CLK_PER_US),
    .HALF_CYC    (HALF_CYC),
    .STRETCH_CYC (STRETCH_CYC),
    .BUF_US      (BUF_US),
    .NUM_PULSES  (NUM_PULSES),
    .SYNC_STAGES (SYNC_STAGES)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .sts         (sts),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .done        (done),
    .success     (success),
    .warnNotIdle (warnNotIdle)
  );

endmodule

// File: rtl/i2crec_chk.sv
module i2crec_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic sclDriveLow,
  input logic sdaDriveLow,
  input logic busy,
  input logic done,
  input logic success,
  input logic warnNotIdle
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDriveLow && !sdaDriveLow));

  // R6: START/STOP pair made with the clock released throughout
  assert_sda_with_scl_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> !sclDriveLow);

  assert_warn_needs_success_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !success) |-> !warnNotIdle);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_when_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_run_needs_request_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startReq));

endmodule

bind i2crec_top i2crec_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .startReq    (startReq),
  .sclDriveLow (sclDriveLow),
  .sdaDriveLow (sdaDriveLow),
  .busy        (busy),
  .done        (done),
  .success     (success),
  .warnNotIdle (warnNotIdle)
);

// File: tb/i2crec_top_tb_top.sv
module i2crec_top_tb_top;

  localparam int CLK_PERIOD  = 10;
  localparam int CLK_PER_US  = 4;
  localparam int HALF_CYC    = 8;
  localparam int STRETCH_CYC = 64;
  localparam int BUF_US      = 60;
  localparam int NUM_PULSES  = 9;
  localparam int BUF_CYC     = BUF_US * CLK_PER_US;

  typedef struct packed {
    logic [7:0] relAt;
    logic [7:0] regAt;
    logic [7:0] strLen;
    logic       extra;
    logic       expSucc;
    logic       expWarn;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'd0,  8'd99, 8'd0,   1'b0, 1'b1, 1'b0},
    '{8'd99, 8'd99, 8'd0,   1'b0, 1'b0, 1'b0},
    '{8'd9,  8'd99, 8'd0,   1'b0, 1'b1, 1'b0},
    '{8'd3,  8'd9,  8'd0,   1'b0, 1'b1, 1'b1},
    '{8'd9,  8'd99, 8'd20,  1'b0, 1'b1, 1'b0},
    '{8'd0,  8'd99, 8'd200, 1'b0, 1'b1, 1'b1},
    '{8'd0,  8'd99, 8'd0,   1'b1, 1'b1, 1'b0},
    '{8'd2,  8'd99, 8'd0,   1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic sclIn, sdaIn;
  logic sclDriveLow, sdaDriveLow, busy, done, success, warnNotIdle;

  int   releaseAt = 0, regrabAt = 99, stretchLen = 0;
  int   stretchCnt = 0, fallCnt = 0;
  logic slaveSdaLow = 1'b0;
  logic sclLinePrev = 1'b1;

  int   sclPulses = 0, sdaPulses = 0, sdaLowLen = 0, doneCnt = 0, gapCnt = 0;
  int   minSclLow = 1000, curSclLow = 0;
  logic badOverlap = 1'b0, gapRun = 1'b0;
  logic prevSclDrv = 1'b0, prevSdaDrv = 1'b0;

  int   nChecks = 0, nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sclIn = !sclDriveLow && (stretchCnt == 0);
  assign sdaIn = !sdaDriveLow && !slaveSdaLow;

  i2crec_top #(
    .CLK_PER_US  (CLK_PER_US),
    .HALF_CYC    (HALF_CYC),
    .STRETCH_CYC (STRETCH_CYC),
    .BUF_US      (BUF_US),
    .NUM_PULSES  (NUM_PULSES),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .startReq    (startReq),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .sclDriveLow (sclDriveLow),
    .sdaDriveLow (sdaDriveLow),
    .busy        (busy),
    .done        (done),
    .success     (success),
    .warnNotIdle (warnNotIdle)
  );

  // Behavioral target and bus monitor, evaluated at falling clock edges.
  always @(negedge clk) begin
    logic lineNow;
    if (prevSclDrv && !sclDriveLow) stretchCnt = stretchLen;
    else if (stretchCnt > 0)        stretchCnt = stretchCnt - 1;
    lineNow = !sclDriveLow && (stretchCnt == 0);
    if (sclLinePrev && !lineNow) fallCnt = fallCnt + 1;
    sclLinePrev = lineNow;
    slaveSdaLow = !(fallCnt >= releaseAt && fallCnt < regrabAt);

    if (!prevSclDrv && sclDriveLow) begin
      sclPulses = sclPulses + 1;
      curSclLow = 0;
    end
    if (sclDriveLow) curSclLow = curSclLow + 1;
    if (prevSclDrv && !sclDriveLow && curSclLow < minSclLow) minSclLow = curSclLow;
    if (!prevSdaDrv && sdaDriveLow) sdaPulses = sdaPulses + 1;
    if (sdaDriveLow) sdaLowLen = sdaLowLen + 1;
    if (sdaDriveLow && sclDriveLow) badOverlap = 1'b1;
    if (prevSdaDrv && !sdaDriveLow) gapRun = 1'b1;
    if (gapRun && !done) gapCnt = gapCnt + 1;
    if (done) begin
      doneCnt = doneCnt + 1;
      gapRun  = 1'b0;
    end
    prevSclDrv = sclDriveLow;
    prevSdaDrv = sdaDriveLow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int gotSucc, gotWarn;
    bit seen;
    @(posedge clk); #1;
    releaseAt  = int'(v.relAt);
    regrabAt   = int'(v.regAt);
    stretchLen = int'(v.strLen);
    fallCnt = 0; sclPulses = 0; sdaPulses = 0; sdaLowLen = 0;
    doneCnt = 0; gapCnt = 0; minSclLow = 1000; badOverlap = 1'b0; gapRun = 1'b0;
    startReq = 1'b1;
    @(posedge clk); #1;
    startReq = 1'b0;
    if (v.extra) begin
      repeat (60) @(posedge clk);
      #1 startReq = 1'b1;
      @(posedge clk); #1;
      startReq = 1'b0;
    end
    seen = 1'b0;
    gotSucc = 0;
    gotWarn = 0;
    for (int k = 0; k < 5000 && !seen; k++) begin
      @(posedge clk); #1;
      if (doneCnt > 0 || done) begin
        seen = 1'b1;
        gotSucc = int'(success);
        gotWarn = int'(warnNotIdle);
      end
    end
    check(seen, $sformatf("R9 vec%0d done seen", idx), int'(seen), 1);
    repeat (40) @(posedge clk);
    #1;
    check(doneCnt == 1, $sformatf("R9/R10 vec%0d done count", idx), doneCnt, 1);
    check(sclPulses == NUM_PULSES, $sformatf("R2/R3/R4/R10 vec%0d scl pulses", idx),
          sclPulses, NUM_PULSES);
    check(minSclLow == HALF_CYC, $sformatf("R2 vec%0d scl low length", idx),
          minSclLow, HALF_CYC);
    check(gotSucc == int'(v.expSucc), $sformatf("R4/R5/R6 vec%0d success", idx),
          gotSucc, int'(v.expSucc));
    check(gotWarn == int'(v.expWarn), $sformatf("R7 vec%0d warn", idx),
          gotWarn, int'(v.expWarn));
    check(!badOverlap, $sformatf("R6 vec%0d sda low with scl low", idx), int'(badOverlap), 0);
    if (v.expSucc) begin
      check(sdaPulses == 1, $sformatf("R6 vec%0d sda pulses", idx), sdaPulses, 1);
      check(sdaLowLen == CLK_PER_US, $sformatf("R6 vec%0d sda low length", idx),
            sdaLowLen, CLK_PER_US);
      check(gapCnt >= BUF_CYC, $sformatf("R8 vec%0d bus free gap", idx), gapCnt, BUF_CYC);
    end else begin
      check(sdaPulses == 0, $sformatf("R5 vec%0d sda pulses", idx), sdaPulses, 0);
    end
    check(!busy && !sclDriveLow && !sdaDriveLow, $sformatf("R1 vec%0d idle released", idx),
          int'({busy, sclDriveLow, sdaDriveLow}), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({busy, done, sclDriveLow, sdaDriveLow} == 4'b0, "R1 during reset",
          int'({busy, done, sclDriveLow, sdaDriveLow}), 0);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check({busy, done, success, warnNotIdle, sclDriveLow, sdaDriveLow} == 6'b0,
          "R1 after reset",
          int'({busy, done, success, warnNotIdle, sclDriveLow, sdaDriveLow}), 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // Directed: with no request, nothing moves on the bus.
    sclPulses = 0; doneCnt = 0;
    repeat (100) @(posedge clk);
    #1;
    check(sclPulses == 0 && doneCnt == 0, "R10 no request no activity",
          sclPulses + doneCnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule